// File: doc/BRIEF.md
# Multitone Symbol Framer with Cyclic Prefix

This block sits after the inverse transform of a multitone transmitter. It takes one 128-sample real time-domain symbol per cycle, reduces every sample to a signed 6-bit code, and forms a 144-sample symbol. The 16-sample guard interval at the front of that symbol repeats the symbol's own tail. Every output symbol leaves the block in a single cycle as one wide word.

Symbols are arranged into repeating frames. Each frame opens with one synchronization symbol, continues with eight training symbols, and ends with 200 live data symbols. The synchronization and training symbols come from a constant pattern that is generated inside the block. While the block sends that preamble it holds the upstream source off through a ready signal. During the data part it passes one accepted symbol per cycle with one cycle of delay.

Clipping and scaling form one operation with a programmable power-of-two threshold. An input of magnitude 32·2^s or more saturates. The rest of the input range is divided by 2^s onto the codes −32..31.

Top module: `dmt_framer`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `out_valid`, `frame_start` and `in_ready` are 0.
- R2: The block emits symbols in the order: one synchronization symbol (frame position 0), eight training symbols (positions 1..8), then 200 data symbols (positions 9..208), and then starts over at position 0. `frame_start` is 1 exactly on the output cycle that carries position 0.
- R3: For a preamble symbol at frame position p (0..8), core sample j (0..127) is the low 6 bits of 53·p + 7·j + 3, read as two's complement.
- R4: The nine preamble symbols appear on nine consecutive cycles, starting with the first clock edge after reset and repeating after every 200th data symbol, whatever `in_valid` does. `in_ready` is 0 while the next symbol to emit is a preamble symbol.
- R5: While the next symbol is a data symbol, `in_ready` is 1. A symbol offered with `in_valid` high is accepted on that clock edge and appears on the outputs one cycle later with `out_valid` high.
- R6: While the next symbol is a data symbol and `in_valid` is low, `out_valid` drops to 0 on the next cycle, `out_samples` holds its previous value and the frame position does not advance.
- R7: Output sample i occupies `out_samples[6*i +: 6]`. For i < 16 it equals core sample 112 + i. For 16 ≤ i < 144 it equals core sample i − 16. Input sample j occupies `in_samples[12*j +: 12]`.
- R8: A data core sample is clamp(floor(x / 2^s), −32, 31), with x the signed 12-bit input sample and s = `clip_shift`. Inputs at or above +32·2^s give 31, and inputs below −32·2^s give −32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream offers a 128-sample symbol |
| in_ready | output | 1 | Block takes an upstream symbol this cycle |
| in_samples | input | 1536 | 128 signed 12-bit time-domain samples |
| clip_shift | input | 4 | Clip threshold exponent s (threshold 32·2^s) |
| out_valid | output | 1 | `out_samples` carries a new symbol |
| frame_start | output | 1 | Output symbol is the synchronization symbol |
| out_samples | output | 864 | 144 signed 6-bit samples, prefix first |

## Verification
All three outputs come from one register stage. A symbol taken or generated on a clock edge is therefore visible from the following falling edge, and `in_ready` depends only on the frame position before that edge. The bench drives inputs at a falling edge and checks `in_ready` right away. It then waits one rising edge and checks `out_valid`, `frame_start` and all 144 samples at the next falling edge against a reference that tracks the frame position separately. Stall cycles are checked in the same slot for a low `out_valid` and unchanged samples.

// File: rtl/dmt_framer.sv
module dmt_framer #(
  parameter int IN_W    = 12,
  parameter int OUT_W   = 6,
  parameter int N_FFT   = 128,
  parameter int N_CP    = 16,
  parameter int N_TRAIN = 8,
  parameter int N_DATA  = 200,
  parameter int SH_W    = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [N_FFT*IN_W-1:0]             in_samples,
  input  logic [SH_W-1:0]                   clip_shift,
  output logic                              out_valid,
  output logic                              frame_start,
  output logic [(N_FFT+N_CP)*OUT_W-1:0]     out_samples
);
  localparam int SYM_N   = N_FFT + N_CP;
  localparam int N_PRE   = 1 + N_TRAIN;
  localparam int N_FRAME = N_PRE + N_DATA;
  localparam int CW      = $clog2(N_FRAME);
  localparam logic signed [IN_W-1:0] HI = IN_W'(2**(OUT_W-1) - 1);
  localparam logic signed [IN_W-1:0] LO = ~HI;

  logic [CW-1:0]          pos;
  logic                   is_pre, emit;
  logic [OUT_W-1:0]       core [N_FFT];
  logic [SYM_N*OUT_W-1:0] sym_n;

  assign is_pre   = pos < CW'(N_PRE);
  assign in_ready = !is_pre;
  assign emit     = is_pre || in_valid;

  for (genvar g = 0; g < N_FFT; g++) begin : g_core
    logic signed [IN_W-1:0] xs, xq;
    assign xs = $signed(in_samples[g*IN_W +: IN_W]);
    assign xq = xs >>> clip_shift;
    assign core[g] = is_pre     ? OUT_W'(32'(pos) * 53 + 7 * g + 3) :
                     (xq > HI)  ? HI[OUT_W-1:0] :
                     (xq < LO)  ? LO[OUT_W-1:0] : xq[OUT_W-1:0];
    assign sym_n[(N_CP+g)*OUT_W +: OUT_W] = core[g];
  end

  for (genvar c = 0; c < N_CP; c++) begin : g_cp
    assign sym_n[c*OUT_W +: OUT_W] = core[N_FFT-N_CP+c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos         <= '0;
      out_valid   <= 1'b0;
      frame_start <= 1'b0;
      out_samples <= '0;
    end else begin
      out_valid   <= emit;
      frame_start <= emit && (pos == '0);
      if (emit) begin
        out_samples <= sym_n;
        pos         <= (pos == CW'(N_FRAME-1)) ? '0 : pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmt_framer_chk.sv
module dmt_framer_chk #(
  parameter int OUT_W   = 6,
  parameter int N_FFT   = 128,
  parameter int N_CP    = 16,
  parameter int N_TRAIN = 8,
  parameter int N_DATA  = 200
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic                          out_valid,
  input logic                          frame_start,
  input logic [(N_FFT+N_CP)*OUT_W-1:0] out_samples
);
  localparam int N_FRAME = 1 + N_TRAIN + N_DATA;
  logic [15:0] n_out;

  always_ff @(posedge clk) begin
    if (!rst_n) n_out <= '0;
    else if (out_valid) n_out <= frame_start ? 16'd1 : n_out + 16'd1;
  end

  AST_START_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (n_out == 16'd0 || n_out == 16'(N_FRAME))); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && n_out == 16'(N_FRAME)) |-> frame_start); // R2
  AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> out_valid); // R2
  AST_TRAIN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (n_out >= 16'd1 && n_out <= 16'(N_TRAIN)) |-> out_valid); // R4
  AST_NO_READY_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (frame_start || n_out < 16'(N_TRAIN))) |-> !in_ready); // R4
  AST_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid); // R6
  AST_ACCEPT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> out_valid); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_samples)); // R6
  AST_PREFIX_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_samples[0 +: N_CP*OUT_W] ==
                   out_samples[N_FFT*OUT_W +: N_CP*OUT_W])); // R7
endmodule

bind dmt_framer dmt_framer_chk #(
  .OUT_W(OUT_W), .N_FFT(N_FFT), .N_CP(N_CP), .N_TRAIN(N_TRAIN), .N_DATA(N_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .frame_start(frame_start), .out_samples(out_samples)
);

// File: tb/dmt_framer_test.sv
module dmt_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 12, OUT_W = 6, N_FFT = 128, N_CP = 16, SH_W = 4;
  localparam int SYM_N = N_FFT + N_CP, N_PRE = 9, N_FRAME = 209;
  localparam int IW = N_FFT * IN_W, OW = SYM_N * OUT_W;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic in_ready, out_valid, frame_start;
  logic [IW-1:0] in_samples = '0;
  logic [SH_W-1:0] clip_shift = '0;
  logic [OW-1:0] out_samples;

  int checks = 0, errors = 0, mpos = 0, frames = 0, dcnt = 0;
  logic [OW-1:0] last_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmt_framer uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .clip_shift(clip_shift), .out_valid(out_valid),
    .frame_start(frame_start), .out_samples(out_samples));

  task automatic chk(input bit ok, input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [OUT_W-1:0] clip_ref(input int x, input int s);
    int q;
    q = (x >= 0) ? (x / (1 << s)) : -((-x + (1 << s) - 1) / (1 << s));
    if (q > 31) q = 31;
    if (q < -32) q = -32;
    return OUT_W'(q);
  endfunction

  function automatic logic [OW-1:0] expect_sym(input int p, input logic [IW-1:0] d, input int s);
    logic [OUT_W-1:0] c [N_FFT];
    logic [OW-1:0] r;
    for (int j = 0; j < N_FFT; j++) begin
      if (p < N_PRE) c[j] = OUT_W'((53 * p + 7 * j + 3) % 64);
      else c[j] = clip_ref(int'($signed(d[j*IN_W +: IN_W])), s);
    end
    for (int i = 0; i < SYM_N; i++)
      r[i*OUT_W +: OUT_W] = (i < N_CP) ? c[N_FFT - N_CP + i] : c[i - N_CP];
    return r;
  endfunction

  task automatic step(input logic v, input logic [IW-1:0] d, input int s);
    logic emit;
    logic [OW-1:0] e;
    in_valid = v; in_samples = d; clip_shift = SH_W'(s);
    #1;
    chk(in_ready == (mpos >= N_PRE), (mpos >= N_PRE) ? "R5 ready" : "R4 ready", OW'(in_ready), OW'(mpos >= N_PRE));
    emit = (mpos < N_PRE) || v;
    e = expect_sym(mpos, d, s);
    @(posedge clk); @(negedge clk);
    chk(out_valid == emit, emit ? "R5 valid" : "R6 valid", OW'(out_valid), OW'(emit));
    if (emit) begin
      chk(frame_start == (mpos == 0), "R2 frame_start", OW'(frame_start), OW'(mpos == 0));
      chk(out_samples == e, (mpos < N_PRE) ? "R3 preamble" : "R8 R7 data", out_samples, e);
      last_out = e;
      if (mpos == N_FRAME - 1) frames++;
      mpos = (mpos == N_FRAME - 1) ? 0 : mpos + 1;
    end else begin
      chk(out_samples == last_out, "R6 hold", out_samples, last_out);
    end
  endtask

  function automatic logic [IW-1:0] fill(input int kind, input int s);
    logic [IW-1:0] d;
    for (int j = 0; j < N_FFT; j++) begin
      case (kind)
        0: d[j*IN_W +: IN_W] = IN_W'(2047);
        1: d[j*IN_W +: IN_W] = IN_W'(-2048);
        2: case (j % 4)
             0: d[j*IN_W +: IN_W] = IN_W'(32 << s);
             1: d[j*IN_W +: IN_W] = IN_W'(-(32 << s));
             2: d[j*IN_W +: IN_W] = IN_W'((32 << s) - 1);
             default: d[j*IN_W +: IN_W] = IN_W'(-(32 << s) - 1);
           endcase
        3: d[j*IN_W +: IN_W] = '0;
        default: d[j*IN_W +: IN_W] = IN_W'($urandom);
      endcase
    end
    return d;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!out_valid && !frame_start && !in_ready, "R1 in reset", OW'({out_valid, frame_start, in_ready}), '0);
    rst_n = 1;
    #1;
    chk(!out_valid && !frame_start && !in_ready, "R1 after release", OW'({out_valid, frame_start, in_ready}), '0);
    while (frames < 2 || mpos < 12) begin
      int s, kind;
      logic v;
      if (mpos < N_PRE) begin
        v = 1'($urandom);
        step(v, fill(4, 2), 2);
      end else begin
        case (dcnt)
          0: begin kind = 0; s = 0; v = 1; end
          1: begin kind = 1; s = 0; v = 1; end
          2: begin kind = 2; s = 3; v = 1; end
          3: begin kind = 3; s = 5; v = 1; end
          4: begin kind = 2; s = 0; v = 1; end
          5: begin kind = 2; s = 6; v = 0; end
          default: begin kind = 4; s = int'($urandom % 7); v = ($urandom % 4) != 0; end
        endcase
        dcnt++;
        step(v, fill(kind, s), s);
      end
    end
    in_valid = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule